// File: doc/BRIEF.md
# Resource Threshold Event Notifier

This block watches three resource fill levels. Each is compared with its own programmed threshold: a per-descriptor level, a total level and a pool level. When a level reaches or passes its threshold, the block reports an event of that kind to a downstream receive queue over a valid/ready handshake. The event carries a two-bit kind code. The block does not count the resources itself; the levels and thresholds come from elsewhere in the chip.

Software controls the block through three settings:
- A global switch that decides whether any events are issued.
- A per-kind arm bit, which software can rewrite at any time with a single write strobe.
- A limit setting. With limit on, each kind reports once and then disarms its own bit in hardware. Any further crossings of that kind are discarded until software arms the bit again. With limit off, the arm bits are never changed by hardware.

Each kind keeps one pending flag. When more than one kind is pending, the pending kinds are presented one at a time in a fixed order. A pending kind is held for as long as the receiver stalls.

Top module: `thr_event_notifier`

## Requirements
- R1: While reset is asserted and after it is released, `evt_valid` is 0 and `arm_state` is 3'b000.
- R2: When a level changes from below its threshold to greater than or equal to it, the global switch is 1 and that kind's arm bit is 1, `evt_valid` is 1 one cycle later. `evt_kind` then shows the kind code: 0 = per-descriptor, 1 = total, 2 = pool. Arm bit positions are bit 0 = per-descriptor, bit 1 = total, bit 2 = pool.
- R3: A level that stays at or above its threshold produces no further event. A new event needs the level to fall below the threshold and rise to it again.
- R4: While `glb_en` is 0, crossings produce no event, and any pending events are discarded one cycle later.
- R5: A crossing of a kind whose arm bit is 0 produces no event and is not remembered.
- R6: With `limit_mode` at 1, a captured crossing clears that kind's arm bit one cycle later.
- R7: After a limit-mode disarm, crossings of that kind are lost until software writes the arm bit to 1. A crossing after that write produces an event again.
- R8: With `limit_mode` at 0 and no software write, the arm bits keep their value whatever events occur.
- R9: When several kinds are pending, `evt_kind` shows the lowest kind code among them.
- R10: While `evt_valid` is 1, `evt_ready` is 0 and `glb_en` is 1, `evt_valid` stays 1 on the next cycle.
- R11: Each handshake (`evt_valid` and `evt_ready` both 1) removes exactly the kind shown on `evt_kind`. The other pending kinds then follow one per handshake.
- R12: If a software write (`arm_wr`) and a hardware disarm happen in the same cycle, the arm bits take the written value `arm_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| glb_en | input | 1 | Global event switch |
| limit_mode | input | 1 | 1 = each kind disarms itself after capturing an event |
| desc_lvl | input | LVL_W | Per-descriptor level |
| desc_thr | input | LVL_W | Per-descriptor threshold |
| tot_lvl | input | LVL_W | Total level |
| tot_thr | input | LVL_W | Total threshold |
| pool_lvl | input | LVL_W | Pool level |
| pool_thr | input | LVL_W | Pool threshold |
| arm_wr | input | 1 | Software write strobe for the arm bits |
| arm_wdata | input | 3 | Arm bit values written when `arm_wr` is 1 |
| arm_state | output | 3 | Current arm bits |
| evt_valid | output | 1 | An event is being offered |
| evt_ready | input | 1 | The receiver accepts the offered event |
| evt_kind | output | 2 | Kind code of the offered event |

## Verification
**Latency.** Every result of this block is due exactly one clock edge after the stimulus that causes it:
- a crossing raises `evt_valid` at the next edge;
- a handshake removes its pending kind at the next edge;
- a disarm, or a software write, shows on `arm_state` at the next edge;
- lowering `glb_en` empties the pending flags at the next edge.

**Bench timing.** The bench drives every input one time unit after a rising edge and advances one edge per step. It samples all outputs one time unit after the edge that follows, so each check lands in the cycle its result is due.

**Reset.** After reset is released, the bench waits three edges before the first stimulus. This covers the two-stage internal reset release.

// File: rtl/thr_evt_pkg.sv
package thr_evt_pkg;
  localparam int unsigned SRC_N  = 3;
  localparam int unsigned KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_DESC  = 2'd0,
    KIND_TOTAL = 2'd1,
    KIND_POOL  = 2'd2
  } evt_kind_e;
endpackage

// File: rtl/thr_rst_sync.sv
module thr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/thr_edge_det.sv
module thr_edge_det #(
  parameter int unsigned LVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] thr,
  output logic             rise
);
  logic above_now;
  logic above_q;

  // The comparison is registered so that a level held high is seen only once.
  always_comb begin
    above_now = (lvl >= thr);
    rise      = above_now & ~above_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) above_q <= 1'b0;
    else         above_q <= above_now;
  end
endmodule

// File: rtl/thr_arm_ctl.sv
module thr_arm_ctl #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         glb_en,
  input  logic         limit_mode,
  input  logic [N-1:0] rise,
  input  logic         arm_wr,
  input  logic [N-1:0] arm_wdata,
  input  logic [N-1:0] gnt,
  output logic [N-1:0] arm_q,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] cap;
  logic [N-1:0] pend_d;
  logic [N-1:0] arm_d;
  logic         arm_ce;

  // Capture, pending and disarm logic, one slice per event kind.
  for (genvar i = 0; i < N; i++) begin : g_slice
    always_comb begin
      cap[i]    = rise[i] & glb_en & arm_q[i];
      pend_d[i] = glb_en & (cap[i] | (pend_q[i] & ~gnt[i]));
    end
  end

  // Arm bits: a software write wins over a hardware disarm.
  always_comb begin
    arm_ce = arm_wr | (limit_mode & (|cap));
    if (arm_wr)          arm_d = arm_wdata;
    else if (limit_mode) arm_d = arm_q & ~cap;
    else                 arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     arm_q <= '0;
    else if (arm_ce) arm_q <= arm_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6: a limit-mode capture without a software write disarms the kind.
    p_limit_disarm_r6: assert property (@(posedge clk) disable iff (!rst_ni)
      limit_mode && rise[i] && glb_en && arm_q[i] && !arm_wr |=> !arm_q[i]);
  end

  // R8: without limit mode or a write, the arm bits hold.
  p_arm_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !limit_mode && !arm_wr |=> arm_q == $past(arm_q));

  // R12: a software write always sets the arm bits to the written value.
  p_sw_wins_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    arm_wr |=> arm_q == $past(arm_wdata));

  // R4: with the global switch off, nothing stays pending.
  p_glb_flush_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !glb_en |=> pend_q == '0);
endmodule

// File: rtl/thr_evt_arb.sv
module thr_evt_arb
  import thr_evt_pkg::*;
#(
  parameter int unsigned N = SRC_N
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [N-1:0]      pend,
  input  logic              ready,
  output logic              valid,
  output logic [KIND_W-1:0] kind,
  output logic [N-1:0]      gnt
);
  logic [N-1:0] pick;

  // Fixed priority: the lowest pending index is offered first.
  always_comb begin
    pick = '0;
    kind = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        pick = '0;
        pick[i] = 1'b1;
        kind = KIND_W'(i);
      end
    end
    valid = |pend;
    gnt   = (valid && ready) ? pick : '0;
  end

  // R11: at most one kind is removed per handshake, and only during one.
  p_one_gnt_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(gnt) && ((gnt != '0) -> (valid && ready)));

  // R9: a pending lowest kind is always the one offered.
  p_prio_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    pend[0] |-> kind == '0);
endmodule

// File: rtl/thr_event_notifier.sv
module thr_event_notifier
  import thr_evt_pkg::*;
#(
  parameter int unsigned LVL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              limit_mode,
  input  logic [LVL_W-1:0]  desc_lvl,
  input  logic [LVL_W-1:0]  desc_thr,
  input  logic [LVL_W-1:0]  tot_lvl,
  input  logic [LVL_W-1:0]  tot_thr,
  input  logic [LVL_W-1:0]  pool_lvl,
  input  logic [LVL_W-1:0]  pool_thr,
  input  logic              arm_wr,
  input  logic [SRC_N-1:0]  arm_wdata,
  output logic [SRC_N-1:0]  arm_state,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [KIND_W-1:0] evt_kind
);
  logic             rst_ni;
  logic [LVL_W-1:0] lvl_a [SRC_N];
  logic [LVL_W-1:0] thr_a [SRC_N];
  logic [SRC_N-1:0] rise;
  logic [SRC_N-1:0] pend;
  logic [SRC_N-1:0] gnt;

  always_comb begin
    lvl_a[KIND_DESC]  = desc_lvl;
    thr_a[KIND_DESC]  = desc_thr;
    lvl_a[KIND_TOTAL] = tot_lvl;
    thr_a[KIND_TOTAL] = tot_thr;
    lvl_a[KIND_POOL]  = pool_lvl;
    thr_a[KIND_POOL]  = pool_thr;
  end

  thr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  for (genvar i = 0; i < SRC_N; i++) begin : g_det
    thr_edge_det #(.LVL_W(LVL_W)) u_det (
      .clk    (clk),
      .rst_ni (rst_ni),
      .lvl    (lvl_a[i]),
      .thr    (thr_a[i]),
      .rise   (rise[i])
    );
  end

  thr_arm_ctl #(.N(SRC_N)) u_arm (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .glb_en     (glb_en),
    .limit_mode (limit_mode),
    .rise       (rise),
    .arm_wr     (arm_wr),
    .arm_wdata  (arm_wdata),
    .gnt        (gnt),
    .arm_q      (arm_state),
    .pend_q     (pend)
  );

  thr_evt_arb #(.N(SRC_N)) u_arb (
    .clk    (clk),
    .rst_ni (rst_ni),
    .pend   (pend),
    .ready  (evt_ready),
    .valid  (evt_valid),
    .kind   (evt_kind),
    .gnt    (gnt)
  );

  // R10: a stalled event stays offered while the global switch is on.
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    evt_valid && !evt_ready && glb_en |=> evt_valid);

  // R1: nothing is offered in the first cycle after reset release.
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_ni) |-> !evt_valid);
endmodule

// File: tb/sim_thr_event_notifier.sv
module sim_thr_event_notifier;
  localparam int LVL_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic glb_en, limit_mode, arm_wr, evt_ready;
  logic [LVL_W-1:0] desc_lvl, desc_thr, tot_lvl, tot_thr, pool_lvl, pool_thr;
  logic [2:0] arm_wdata;
  logic [2:0] arm_state;
  logic       evt_valid;
  logic [1:0] evt_kind;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  thr_event_notifier #(.LVL_W(LVL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .limit_mode(limit_mode),
    .desc_lvl(desc_lvl), .desc_thr(desc_thr), .tot_lvl(tot_lvl), .tot_thr(tot_thr),
    .pool_lvl(pool_lvl), .pool_thr(pool_thr), .arm_wr(arm_wr), .arm_wdata(arm_wdata),
    .arm_state(arm_state), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_kind(evt_kind)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_arm(input logic [2:0] v);
    arm_wr = 1'b1; arm_wdata = v;
    tick();
    arm_wr = 1'b0;
  endtask

  task automatic take();
    evt_ready = 1'b1;
    tick();
    evt_ready = 1'b0;
  endtask

  task automatic quiesce();
    desc_lvl = '0; tot_lvl = '0; pool_lvl = '0;
    evt_ready = 1'b1;
    repeat (4) tick();
    evt_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    glb_en = 1'b0; limit_mode = 1'b0; arm_wr = 1'b0; arm_wdata = '0; evt_ready = 1'b0;
    desc_lvl = '0; tot_lvl = '0; pool_lvl = '0;
    desc_thr = 16'd100; tot_thr = 16'd500; pool_thr = 16'd40;
    repeat (3) tick();
    chk("R1 valid in reset", evt_valid, 0);
    chk("R1 arm in reset", arm_state, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 valid after reset", evt_valid, 0);
    chk("R1 arm after reset", arm_state, 0);
  endtask

  task automatic t_basic();
    glb_en = 1'b1; limit_mode = 1'b0;
    write_arm(3'b111);
    desc_lvl = 16'd100;          // equal counts as reached
    tick();
    chk("R2 desc valid", evt_valid, 1);
    chk("R2 desc kind", evt_kind, 0);
    take();
    chk("R11 desc removed", evt_valid, 0);
    tot_lvl = 16'd600;
    tick();
    chk("R2 total kind", evt_kind, 1);
    take();
    quiesce();
  endtask

  task automatic t_hold();
    pool_lvl = 16'd50;
    tick();
    chk("R3 first pool", evt_kind, 2);
    take();
    repeat (3) tick();
    chk("R3 held level no retrigger", evt_valid, 0);
    pool_lvl = 16'd10; tick();
    pool_lvl = 16'd45; tick();
    chk("R3 re-crossing fires", evt_valid, 1);
    take();
    quiesce();
  endtask

  task automatic t_priority();
    desc_lvl = 16'd200; tot_lvl = 16'd700; pool_lvl = 16'd90;
    tick();
    chk("R9 lowest kind first", evt_kind, 0);
    repeat (3) tick();
    chk("R10 stalled valid", evt_valid, 1);
    chk("R10 stalled kind", evt_kind, 0);
    take();
    chk("R11 next total", evt_kind, 1);
    take();
    chk("R11 next pool", evt_kind, 2);
    take();
    chk("R11 all drained", evt_valid, 0);
    quiesce();
  endtask

  task automatic t_global();
    glb_en = 1'b0;
    tot_lvl = 16'd600;
    tick();
    chk("R4 no event while off", evt_valid, 0);
    tot_lvl = '0;
    glb_en = 1'b1;
    pool_lvl = 16'd50;
    tick();
    chk("R4 pool pending", evt_valid, 1);
    glb_en = 1'b0; tick();
    glb_en = 1'b1; tick();
    chk("R4 pending discarded", evt_valid, 0);
    quiesce();
  endtask

  task automatic t_arm_off();
    write_arm(3'b101);
    tot_lvl = 16'd600;
    tick();
    chk("R5 disarmed kind dropped", evt_valid, 0);
    write_arm(3'b111);
    tick();
    chk("R5 not remembered", evt_valid, 0);
    quiesce();
  endtask

  task automatic t_nolimit();
    limit_mode = 1'b0;
    desc_lvl = 16'd150; tick(); take();
    desc_lvl = '0; tick();
    desc_lvl = 16'd150; tick();
    chk("R8 second event", evt_valid, 1);
    chk("R8 arm unchanged", arm_state, 7);
    quiesce();
  endtask

  task automatic t_limit();
    limit_mode = 1'b1;
    write_arm(3'b111);
    desc_lvl = 16'd120;
    tick();
    chk("R6 event issued", evt_kind, 0);
    chk("R6 arm bit0 cleared", arm_state, 6);
    take();
    desc_lvl = '0; tick();
    desc_lvl = 16'd120; tick();
    chk("R7 crossing lost", evt_valid, 0);
    desc_lvl = '0; tick();
    write_arm(3'b111);
    desc_lvl = 16'd120; tick();
    chk("R7 rearmed fires", evt_valid, 1);
    take();
    quiesce();
  endtask

  task automatic t_precedence();
    limit_mode = 1'b1;
    write_arm(3'b111);
    pool_lvl = 16'd70;
    arm_wr = 1'b1; arm_wdata = 3'b111;
    tick();
    arm_wr = 1'b0;
    chk("R12 write wins", arm_state, 7);
    chk("R12 event kind", evt_kind, 2);
    take();
    quiesce();
    limit_mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_hold();
    t_priority();
    t_global();
    t_arm_off();
    t_nolimit();
    t_limit();
    t_precedence();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule